// File: doc/BRIEF.md
# Prioritized Five-Source Interrupt Controller

This block collects interrupt requests from five on-chip sources (vertical blank, display status, timer, serial link and keypad). It presents them to an 8-bit CPU as a single request line with a vector address. The CPU sees two byte-wide registers in its memory map: an enable mask at 0xFFFF and a pending-flag register at 0xFF0F. Devices raise their flag with a one-cycle pulse. Software may read and write both registers at any time.

A request is signalled only while the global master enable is set. The lowest-numbered source that is both pending and enabled wins, and its vector is 0x40 plus eight times its bit number. When the CPU acknowledges, the winner's flag is dropped and the master enable is cleared. The master enable comes back through an explicit enable pulse or a return-from-handler pulse. Because the enable pulse may be issued inside a handler, nested servicing is possible.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the enable mask, the flag register and the master enable are all 0. irq_out is 0, irq_vector is 0x00 and bus_rdata is 0x00.
- R2: A write with bus_wr to 0xFFFF or 0xFF0F stores bus_wdata[4:0] into the enable mask or the flag register. A bus_rd returns that register on bus_rdata one cycle later, with bits 7..5 reading as 1. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R3: A pulse on dev_req[i] sets flag bit i: bit 0 vertical blank, 1 display status, 2 timer, 3 serial link, 4 keypad. If a CPU write to 0xFF0F lands in the same cycle, the device set takes precedence over the written value.
- R4: irq_out is 1 exactly when the master enable is 1 and enable & flags is nonzero. It follows register state with no added latency.
- R5: While irq_out is 1, irq_vector equals 0x40 + 8*i, where i is the lowest bit set in enable & flags.
- R6: A pending flag whose enable bit is 0 raises no request and stays set.
- R7: irq_ack while irq_out is 1 clears only the winning source's flag bit and clears the master enable. irq_ack while irq_out is 0 has no effect.
- R8: ime_set or reti sets the master enable. ime_clr or an accepted acknowledge clears it, and a clear wins over a set in the same cycle.
- R9: If the master enable is set again while other requests are still pending, a new request is raised. A newly arriving higher-priority source then replaces the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Registered read data |
| dev_req | input | 5 | One-cycle device request pulses |
| irq_ack | input | 1 | CPU accepts current request |
| ime_set | input | 1 | Enable-interrupts pulse |
| ime_clr | input | 1 | Disable-interrupts pulse |
| reti | input | 1 | Return-from-handler pulse |
| irq_out | output | 1 | Interrupt request to CPU |
| irq_vector | output | 8 | Vector address of winning source |
| ime | output | 1 | Master enable state |

## Verification
The hardest condition to reach is a same-cycle collision: an acknowledge landing with a return pulse, an enable pulse meeting a disable pulse, or a device pulse hitting a CPU write that clears the flags. The bench drives each collision on one chosen cycle and then reads the flags and the master enable back through the ports. Priority is covered by sweeping all 1024 mask and flag combinations. The nested case is reached by acknowledging, re-enabling while a lower source is still pending, and then pulsing a higher source.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC_DEF   = 5;
  localparam int SRC_VBLANK = 0;
  localparam int SRC_DISP   = 1;
  localparam int SRC_TIMER  = 2;
  localparam int SRC_LINK   = 3;
  localparam int SRC_KEYS   = 4;
endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
  parameter int NSRC = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   dev_req,
  input  logic [NSRC-1:0]   clr_mask,
  output logic [NSRC-1:0]   ie_q,
  output logic [NSRC-1:0]   if_q,
  output logic [NSRC-1:0]   ie_next,
  output logic [NSRC-1:0]   if_next,
  output logic [DATA_W-1:0] rd_data
);
  logic en_hit, fl_hit;
  logic [NSRC-1:0] if_base;
  logic [DATA_W-1:0] rd_val;
  logic unused_hi;

  assign en_hit = (bus_addr == EN_ADDR);
  assign fl_hit = (bus_addr == FLAG_ADDR);
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

  assign ie_next = (bus_wr && en_hit) ? bus_wdata[NSRC-1:0] : ie_q;
  assign if_base = (bus_wr && fl_hit) ? bus_wdata[NSRC-1:0] : if_q;
  // acknowledge clear applied first, device set last so it dominates
  assign if_next = (if_base & ~clr_mask) | dev_req;

  always_comb begin
    rd_val = '0;
    if (en_hit) begin
      rd_val = '1;
      rd_val[NSRC-1:0] = ie_q;
    end else if (fl_hit) begin
      rd_val = '1;
      rd_val[NSRC-1:0] = if_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= '0;
      if_q    <= '0;
      rd_data <= '0;
    end else begin
      ie_q <= ie_next;
      if_q <= if_next;
      if (bus_rd) rd_data <= rd_val;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC = 5,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  pend,
  output logic             any,
  output logic [NSRC-1:0]  oh,
  output logic [IDX_W-1:0] idx
);
  logic [NSRC:0] seen;
  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_chain
      assign oh[i]     = pend[i] & ~seen[i];
      assign seen[i+1] = seen[i] | pend[i];
    end
  endgenerate

  assign any = seen[NSRC];

  always_comb begin
    idx = '0;
    for (int k = 0; k < NSRC; k++)
      if (oh[k]) idx = IDX_W'(k);
  end
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk,
  input  logic rst,
  input  logic ime_set,
  input  logic ime_clr,
  input  logic reti,
  input  logic accept,
  output logic ime_q,
  output logic ime_next
);
  always_comb begin
    if (accept || ime_clr)     ime_next = 1'b0;
    else if (ime_set || reti)  ime_next = 1'b1;
    else                       ime_next = ime_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ime_q <= 1'b0;
    else     ime_q <= ime_next;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h40,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   dev_req,
  input  logic              irq_ack,
  input  logic              ime_set,
  input  logic              ime_clr,
  input  logic              reti,
  output logic              irq_out,
  output logic [DATA_W-1:0] irq_vector,
  output logic              ime
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] ie_q, if_q, ie_next, if_next, clr_mask, pend_next, sel_oh, win_q;
  logic [IDX_W-1:0] sel_idx;
  logic sel_any, accept, ime_next;
  logic [DATA_W-1:0] vec_next;

  assign accept   = irq_ack && irq_out;
  assign clr_mask = accept ? win_q : '0;

  irq_flag_regs #(
    .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .dev_req(dev_req),
    .clr_mask(clr_mask), .ie_q(ie_q), .if_q(if_q),
    .ie_next(ie_next), .if_next(if_next), .rd_data(bus_rdata)
  );

  irq_master_en u_ime (
    .clk(clk), .rst(rst), .ime_set(ime_set), .ime_clr(ime_clr),
    .reti(reti), .accept(accept), .ime_q(ime), .ime_next(ime_next)
  );

  // arbitrate on next state so the registered outputs track the registers
  assign pend_next = ie_next & if_next & {NSRC{ime_next}};

  irq_prio_sel #(.NSRC(NSRC)) u_sel (
    .pend(pend_next), .any(sel_any), .oh(sel_oh), .idx(sel_idx)
  );

  assign vec_next = VEC_BASE + DATA_W'(VEC_STEP * int'(sel_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out    <= 1'b0;
      irq_vector <= '0;
      win_q      <= '0;
    end else begin
      irq_out    <= sel_any;
      irq_vector <= sel_any ? vec_next : '0;
      win_q      <= sel_oh;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_ack,
  input logic              irq_out,
  input logic [DATA_W-1:0] irq_vector,
  input logic              ime,
  input logic              ime_clr,
  input logic [NSRC-1:0]   dev_req,
  input logic [NSRC-1:0]   ie_q,
  input logic [NSRC-1:0]   if_q
);
  a_r4_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_out == (ime && (|(ie_q & if_q))));

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_vector[2:0] == 3'd0 && irq_vector >= 8'h40 && irq_vector <= 8'h60));

  a_r3_dev_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|dev_req) |=> ((if_q & $past(dev_req)) == $past(dev_req)));

  a_r7_ack_drops_ime: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_out) |=> (!ime && !irq_out));

  a_r8_clr_wins: assert property (@(posedge clk) disable iff (rst)
    ime_clr |=> !ime);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_out(irq_out),
  .irq_vector(irq_vector), .ime(ime), .ime_clr(ime_clr),
  .dev_req(dev_req), .ie_q(ie_q), .if_q(if_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] dev_req = '0;
  logic irq_ack = 1'b0, ime_set = 1'b0, ime_clr = 1'b0, reti = 1'b0;
  logic irq_out, ime;
  logic [7:0] irq_vector;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_req(dev_req),
    .irq_ack(irq_ack), .ime_set(ime_set), .ime_clr(ime_clr), .reti(reti),
    .irq_out(irq_out), .irq_vector(irq_vector), .ime(ime)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic int lowest(input logic [4:0] p);
    for (int i = 4; i >= 0; i--) if (p[i]) lowest = i;
    if (p == 5'd0) lowest = -1;
  endfunction

  task automatic pulse_set();
    ime_set = 1'b1; tick(); ime_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [4:0] e, f, exp_f;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_out", irq_out, 0);
    chk("R1 vector", irq_vector, 0);
    chk("R1 ime", ime, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(16'hFFFF, v); chk("R1 enable reads E0", v, 8'hE0);
    rd(16'hFF0F, v); chk("R1 flags read E0", v, 8'hE0);

    // R2 unmapped address
    wr(16'hFF10, 8'hFF);
    rd(16'hFF10, v); chk("R2 unmapped read", v, 8'h00);
    rd(16'hFFFF, v); chk("R2 unmapped write ignored (enable)", v, 8'hE0);
    rd(16'hFF0F, v); chk("R2 unmapped write ignored (flags)", v, 8'hE0);

    // R4 R5 sweep of all mask and flag pairs with master enable on
    pulse_set();
    for (int ei = 0; ei < 32; ei++) begin
      for (int fi = 0; fi < 32; fi++) begin
        e = 5'(ei); f = 5'(fi);
        wr(16'hFFFF, {3'b000, e});
        wr(16'hFF0F, {3'b111, f});
        chk("R4 irq level", irq_out, ((e & f) != 0));
        if ((e & f) != 0)
          chk("R5 vector", irq_vector, 32'h40 + 8 * lowest(e & f));
        if (ei == fi) begin
          rd(16'hFF0F, v); chk("R2 flag readback", v, {3'b111, f});
          rd(16'hFFFF, v); chk("R2 enable readback", v, {3'b111, e});
        end
      end
    end
    ime_clr = 1'b1; tick(); ime_clr = 1'b0;
    chk("R8 ime_clr clears", ime, 0);
    chk("R4 no irq when ime off", irq_out, 0);

    // R6 disabled source stays pending
    wr(16'hFF0F, 8'h00);
    wr(16'hFFFF, 8'h1B);
    pulse_set();
    dev_req = 5'b00100; tick(); dev_req = '0;
    chk("R6 disabled timer no irq", irq_out, 0);
    rd(16'hFF0F, v); chk("R6 timer flag kept", v, 8'hE4);
    wr(16'hFFFF, 8'h1F);
    chk("R6 enabling raises irq", irq_out, 1);
    chk("R6 vector timer", irq_vector, 8'h50);

    // R7 acknowledge sweep
    for (int fi = 1; fi < 32; fi++) begin
      f = 5'(fi);
      ime_clr = 1'b1; tick(); ime_clr = 1'b0;
      wr(16'hFF0F, {3'b000, f});
      pulse_set();
      chk("R5 vector before ack", irq_vector, 32'h40 + 8 * lowest(f));
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R7 ime cleared by ack", ime, 0);
      chk("R7 irq dropped by ack", irq_out, 0);
      exp_f = f & ~(5'd1 << lowest(f));
      rd(16'hFF0F, v); chk("R7 only winner cleared", v, {3'b111, exp_f});
    end

    // R7 acknowledge with no request
    wr(16'hFF0F, 8'h03);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    rd(16'hFF0F, v); chk("R7 idle ack ignored", v, 8'hE3);

    // R3 per-source mapping and precedence over CPU write
    for (int i = 0; i < 5; i++) begin
      wr(16'hFF0F, 8'h00);
      dev_req = 5'(1 << i); tick(); dev_req = '0;
      rd(16'hFF0F, v); chk("R3 source bit mapping", v, 8'hE0 | 8'(1 << i));
    end
    bus_addr = 16'hFF0F; bus_wdata = 8'h00; bus_wr = 1'b1; dev_req = 5'b01000;
    tick();
    bus_wr = 1'b0; dev_req = '0;
    rd(16'hFF0F, v); chk("R3 device beats write", v, 8'hE8);

    // R8 conflicts
    ime_set = 1'b1; ime_clr = 1'b1; tick(); ime_set = 1'b0; ime_clr = 1'b0;
    chk("R8 clr beats set", ime, 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R8 reti sets", ime, 1);
    wr(16'hFF0F, 8'h01);
    chk("R8 irq up before ack", irq_out, 1);
    irq_ack = 1'b1; reti = 1'b1; tick(); irq_ack = 1'b0; reti = 1'b0;
    chk("R8 ack beats reti", ime, 0);

    // R9 nesting
    wr(16'hFF0F, 8'h14);
    pulse_set();
    chk("R9 first vector", irq_vector, 8'h50);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R9 irq off in handler", irq_out, 0);
    pulse_set();
    chk("R9 nested irq raised", irq_out, 1);
    chk("R9 nested vector", irq_vector, 8'h60);
    dev_req = 5'b00001; tick(); dev_req = '0;
    chk("R9 higher source preempts", irq_vector, 8'h40);

    finish_run();
  end
endmodule